// File: doc/BRIEF.md
# Receiver Error Status and Interrupt Unit

This unit collects error events for a two-lane camera serial receiver. There are two kinds. Protocol errors are reported per packet and carry the packet's virtual channel and data type on shared side-information inputs. Physical-layer errors are reported per data lane. Each event is a single-cycle pulse. The unit stores every event in a sticky status flag. An interrupt-enable register masks the flags, and a write-one-to-clear register clears them. A registered interrupt line goes high while any enabled flag is set.

For four protocol error classes, the unit also records the virtual channel and data type of the packet that raised the flag. Only the first offending packet is kept. A new value can be captured only after software has cleared the flag. Registers are reached through a simple port: a write strobe, an address and write data, with a combinational read.

Register map by address: 0 protocol status, 1 protocol enable, 2 protocol clear, 3 lane status, 4 lane enable, 5 lane clear, 6 capture word A, 7 capture word B.

Top module: `err_status_unit`

## Requirements
- R1: Each pulse on `glb_evt` sets one protocol status bit. The input index maps to a bit as follows: index 0 CRC → bit 24, 1 corrected ECC → bit 26, 2 uncorrectable ECC → bit 25, 3 ID error → bit 27, 4 short packet → bit 28, 5 sync → bit 30, 6 clock-domain FIFO full → bit 21. The bit is readable at address 0 after the clock edge that samples the pulse.
- R2: Lane error input `lane_evt[l*5+k]` (k = 0..4) sets lane status bit l*8+k at address 3. Lane 0 uses bits 0..4 and lane 1 uses bits 8..12.
- R3: A status flag stays set, with no further events, until it is cleared.
- R4: Writing to address 2 or 5 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged. Both clear addresses read as 0.
- R5: If an event and a clear hit the same flag in the same cycle, the flag ends up set. Other bits cleared in that same write are still cleared.
- R6: The enable registers at addresses 1 and 4 use the same bit positions as their status registers. Bits with no defined flag read as 0 in both the status and the enable registers.
- R7: `irq` is registered. It goes high one cycle after any status bit and its matching enable bit are both 1. It stays low while every flag is masked.
- R8: Capture fields for a class are written only when that class's event arrives while its flag is 0. Later events of that class leave the fields unchanged until the flag is cleared.
- R9: Capture word A (address 6) holds three slots. The CRC slot has DT in bits 5:0 and VC in bits 7:6. The corrected-ECC slot has DT in bits 13:8 and VC in bits 15:14. The ID-error slot has DT in bits 21:16 and VC in bits 23:22.
- R10: Capture word B (address 7) holds the short-packet DT in bits 5:0 and VC in bits 7:6, and the sync-error VC in bits 19:18. Uncorrectable ECC and FIFO-full events capture nothing.
- R11: After reset, every register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_evt | input | 7 | Protocol error pulses, one per class |
| evt_vc | input | 2 | Virtual channel of the current packet |
| evt_dt | input | 6 | Data type of the current packet |
| lane_evt | input | 10 | Lane error pulses, 5 per lane |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear write and an event landing on the same flag in the same cycle. A close second is a repeat event arriving while a flag is still set, where the first capture must survive. The stimulus first sets two flags. It then drives one class's event and a clear of both bits on the same negative edge. Only the untouched bit must drop. Every class is then swept through three phases: first event, repeat event with different side data, and a fresh event after a clear. This shows when the capture fields may move and when they must stay fixed.

// File: rtl/esu_pkg.sv
package esu_pkg;
    localparam int NCLS    = 7;
    localparam int LERR    = 5;
    localparam int LSTRIDE = 8;
    localparam int DW      = 32;

    typedef enum logic [2:0] {
        CL_CRC  = 3'd0,
        CL_CECC = 3'd1,
        CL_ECC  = 3'd2,
        CL_ID   = 3'd3,
        CL_SPKT = 3'd4,
        CL_SYNC = 3'd5,
        CL_FIFO = 3'd6
    } err_cls_e;

    typedef enum logic [2:0] {
        RA_GSTS = 3'd0,
        RA_GEN  = 3'd1,
        RA_GCLR = 3'd2,
        RA_LSTS = 3'd3,
        RA_LEN  = 3'd4,
        RA_LCLR = 3'd5,
        RA_CAPA = 3'd6,
        RA_CAPB = 3'd7
    } reg_addr_e;

    localparam int GPOS [NCLS] = '{24, 26, 25, 27, 28, 30, 21};

    function automatic logic [DW-1:0] glb_expand(input logic [NCLS-1:0] e);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < NCLS; i++) r[GPOS[i]] = e[i];
        return r;
    endfunction

    function automatic logic [DW-1:0] glb_mask();
        return glb_expand('1);
    endfunction

    function automatic logic [DW-1:0] lane_mask(input int lanes);
        logic [DW-1:0] r;
        r = '0;
        for (int l = 0; l < lanes; l++)
            for (int k = 0; k < LERR; k++) r[l*LSTRIDE+k] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/esu_flag_bank.sv
module esu_flag_bank #(
    parameter int                  W    = 32,
    parameter logic [W-1:0]        MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] en_o
);
    logic [W-1:0] sts_q, en_q, clr_bits, sts_d;

    assign clr_bits = clr_we ? wdata : '0;
    // event wins over clear: set applied after clear
    assign sts_d    = ((sts_q & ~clr_bits) | set_i) & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            if (en_we) en_q <= wdata & MASK;
        end
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;
endmodule

// File: rtl/esu_capture.sv
module esu_capture #(
    parameter int NCLS = 7,
    parameter int VC_W = 2,
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] first_i,
    input  logic [VC_W-1:0] vc_i,
    input  logic [DT_W-1:0] dt_i,
    output logic [31:0]     cap_a_o,
    output logic [31:0]     cap_b_o
);
    import esu_pkg::*;
    localparam int SLOT  = 8;
    localparam int SW    = VC_W + DT_W;
    localparam int NSLOT = 3;
    localparam int SLOT_CLS [NSLOT] = '{int'(CL_CRC), int'(CL_CECC), int'(CL_ID)};
    localparam int SYNC_VC_LSB = 18;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [SW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= '0;
            else if (first_i[SLOT_CLS[s]]) q <= {vc_i, dt_i};
        end
        assign cap_a_o[s*SLOT +: SW] = q;
        if (SW < SLOT) begin : g_pad
            assign cap_a_o[s*SLOT+SW +: SLOT-SW] = '0;
        end
    end
    assign cap_a_o[31:NSLOT*SLOT] = '0;

    logic [SW-1:0]   spkt_q;
    logic [VC_W-1:0] sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spkt_q <= '0;
            sync_q <= '0;
        end else begin
            if (first_i[CL_SPKT]) spkt_q <= {vc_i, dt_i};
            if (first_i[CL_SYNC]) sync_q <= vc_i;
        end
    end

    always_comb begin
        cap_b_o = '0;
        cap_b_o[SW-1:0] = spkt_q;
        cap_b_o[SYNC_VC_LSB +: VC_W] = sync_q;
    end
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit #(
    parameter int LANES  = 2,
    parameter int VC_W   = 2,
    parameter int DT_W   = 6,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [esu_pkg::NCLS-1:0]      glb_evt,
    input  logic [VC_W-1:0]               evt_vc,
    input  logic [DT_W-1:0]               evt_dt,
    input  logic [LANES*esu_pkg::LERR-1:0] lane_evt,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic                          irq
);
    import esu_pkg::*;
    localparam int LANE_USED = LANES * LSTRIDE;
    localparam logic [31:0] GMASK = glb_mask();
    localparam logic [31:0] LMASK = lane_mask(LANES);

    logic [31:0] gset, lset, gsts, gen, lsts, len, cap_a, cap_b;
    logic [NCLS-1:0] first_evt;
    logic irq_q;

    assign gset = glb_expand(glb_evt);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lset[l*LSTRIDE +: LERR] = lane_evt[l*LERR +: LERR];
        assign lset[l*LSTRIDE+LERR +: LSTRIDE-LERR] = '0;
    end
    if (LANE_USED < 32) begin : g_lpad
        assign lset[31:LANE_USED] = '0;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_first
        assign first_evt[c] = glb_evt[c] & ~gsts[GPOS[c]];
    end

    esu_flag_bank #(.W(32), .MASK(GMASK)) u_gbank (
        .clk(clk), .rst_n(rst_n), .set_i(gset),
        .clr_we(reg_wr && reg_addr == ADDR_W'(RA_GCLR)),
        .en_we(reg_wr && reg_addr == ADDR_W'(RA_GEN)),
        .wdata(reg_wdata), .sts_o(gsts), .en_o(gen)
    );

    esu_flag_bank #(.W(32), .MASK(LMASK)) u_lbank (
        .clk(clk), .rst_n(rst_n), .set_i(lset),
        .clr_we(reg_wr && reg_addr == ADDR_W'(RA_LCLR)),
        .en_we(reg_wr && reg_addr == ADDR_W'(RA_LEN)),
        .wdata(reg_wdata), .sts_o(lsts), .en_o(len)
    );

    esu_capture #(.NCLS(NCLS), .VC_W(VC_W), .DT_W(DT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .first_i(first_evt),
        .vc_i(evt_vc), .dt_i(evt_dt), .cap_a_o(cap_a), .cap_b_o(cap_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|(gsts & gen)) | (|(lsts & len));
    end
    assign irq = irq_q;

    always_comb begin
        case (reg_addr)
            ADDR_W'(RA_GSTS): reg_rdata = gsts;
            ADDR_W'(RA_GEN):  reg_rdata = gen;
            ADDR_W'(RA_LSTS): reg_rdata = lsts;
            ADDR_W'(RA_LEN):  reg_rdata = len;
            ADDR_W'(RA_CAPA): reg_rdata = cap_a;
            ADDR_W'(RA_CAPB): reg_rdata = cap_b;
            default:          reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/esu_checker.sv
module esu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  glb_evt,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] gsts,
    input logic [31:0] lsts,
    input logic [31:0] gen,
    input logic [31:0] len,
    input logic [31:0] cap_a,
    input logic [31:0] cap_b,
    input logic        irq
);
    import esu_pkg::*;

    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_evt != 0) |=> ((gsts & $past(glb_expand(glb_evt))) == $past(glb_expand(glb_evt))));

    p_sticky_glb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'(RA_GCLR)) |=> (($past(gsts) & ~gsts) == 0));

    p_sticky_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'(RA_LCLR)) |=> (($past(lsts) & ~lsts) == 0));

    p_undef_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gsts | gen) & ~glb_mask()) == 0 && ((lsts | len) & ~lane_mask(2)) == 0);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen == 0 && len == 0) |=> !irq);

    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_evt == 0) |=> ($stable(cap_a) && $stable(cap_b)));
endmodule

bind err_status_unit esu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .glb_evt(glb_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .gsts(gsts), .lsts(lsts), .gen(gen), .len(len),
    .cap_a(cap_a), .cap_b(cap_b), .irq(irq)
);

// File: tb/sim_err_status_unit.sv
module sim_err_status_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [6:0]  glb_evt = '0;
    logic [1:0]  evt_vc = '0;
    logic [5:0]  evt_dt = '0;
    logic [9:0]  lane_evt = '0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    err_status_unit u0 (.*);

    function automatic int gpos(input int c);
        case (c)
            0: return 24; 1: return 26; 2: return 25; 3: return 27;
            4: return 28; 5: return 30; default: return 21;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic gpulse(input int c, input logic [1:0] vc, input logic [5:0] dt);
        @(negedge clk); glb_evt = 7'(1 << c); evt_vc = vc; evt_dt = dt;
        @(negedge clk); glb_evt = '0;
    endtask

    // apply expected capture update for class c
    task automatic cap_model(input int c, input logic [1:0] vc, input logic [5:0] dt,
                             inout logic [31:0] ea, inout logic [31:0] eb);
        case (c)
            0: ea = (ea & ~32'h0000_00FF) | {24'd0, vc, dt};
            1: ea = (ea & ~32'h0000_FF00) | ({24'd0, vc, dt} << 8);
            3: ea = (ea & ~32'h00FF_0000) | ({24'd0, vc, dt} << 16);
            4: eb = (eb & ~32'h0000_00FF) | {24'd0, vc, dt};
            5: eb = (eb & ~32'h000C_0000) | ({30'd0, vc} << 18);
            default: ;
        endcase
    endtask

    initial begin
        logic [31:0] d, ea, eb, gm;
        ea = 0; eb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(a, d); check("R11 reset reg", d, 0);
        end
        check("R11 reset irq", {31'd0, irq}, 0);

        // sweep all protocol classes
        for (int c = 0; c < 7; c++) begin
            logic [1:0] v1, v2, v3;
            logic [5:0] t1, t2, t3;
            v1 = 2'(c); t1 = 6'(c*9+5);
            v2 = 2'(c+1); t2 = 6'(c*7+33);
            v3 = 2'(c+2); t3 = 6'(c*5+17);
            gpulse(c, v1, t1);
            cap_model(c, v1, t1, ea, eb);
            rd(0, d); check("R1 status bit", d, 32'(1) << gpos(c));
            rd(6, d); check("R9 capture A", d, ea);
            rd(7, d); check("R10 capture B", d, eb);
            gpulse(c, v2, t2);
            rd(6, d); check("R8 hold A", d, ea);
            rd(7, d); check("R8 hold B", d, eb);
            repeat (5) @(negedge clk);
            rd(0, d); check("R3 sticky", d, 32'(1) << gpos(c));
            wr(2, 32'h0);
            rd(0, d); check("R4 zero write", d, 32'(1) << gpos(c));
            rd(2, d); check("R4 clear reads 0", d, 0);
            wr(2, 32'(1) << gpos(c));
            rd(0, d); check("R4 cleared", d, 0);
            gpulse(c, v3, t3);
            cap_model(c, v3, t3, ea, eb);
            rd(6, d); check("R8 recapture A", d, ea);
            rd(7, d); check("R8 recapture B", d, eb);
            wr(2, 32'hFFFF_FFFF);
        end

        // sweep lane errors
        for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk); lane_evt = 10'(1 << (l*5+k));
                @(negedge clk); lane_evt = '0;
                rd(3, d); check("R2 lane bit", d, 32'(1) << (l*8+k));
                wr(5, 32'h0);
                rd(3, d); check("R4 lane zero write", d, 32'(1) << (l*8+k));
                wr(5, 32'(1) << (l*8+k));
                rd(3, d); check("R4 lane cleared", d, 0);
            end
        end

        // enable positions
        gm = 0;
        for (int c = 0; c < 7; c++) gm |= 32'(1) << gpos(c);
        wr(1, 32'hFFFF_FFFF); rd(1, d); check("R6 glb enable mask", d, gm);
        wr(4, 32'hFFFF_FFFF); rd(4, d); check("R6 lane enable mask", d, 32'h0000_1F1F);
        wr(1, 0); wr(4, 0);

        // event wins over clear
        @(negedge clk); glb_evt = 7'b000_0101;
        @(negedge clk); glb_evt = 7'b000_0100; reg_wr = 1; reg_addr = 3'd2;
        reg_wdata = (32'(1) << 24) | (32'(1) << 25);
        @(negedge clk); glb_evt = '0; reg_wr = 0; reg_wdata = 0;
        rd(0, d); check("R5 event wins", d, 32'(1) << 25);

        // interrupt: masked, then enabled
        repeat (2) @(negedge clk);
        check("R7 masked irq", {31'd0, irq}, 0);
        wr(1, 32'(1) << 25);
        check("R7 irq registered", {31'd0, irq}, 0);
        @(negedge clk);
        check("R7 irq set", {31'd0, irq}, 1);
        wr(2, 32'(1) << 25);
        @(negedge clk);
        check("R7 irq drops", {31'd0, irq}, 0);
        wr(1, 0);
        wr(4, 32'(1) << 9);
        @(negedge clk); lane_evt = 10'(1 << 6);
        @(negedge clk); lane_evt = '0;
        check("R7 lane irq lag", {31'd0, irq}, 0);
        @(negedge clk);
        check("R7 lane irq", {31'd0, irq}, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule